// File: doc/BRIEF.md
# Rotating Line Buffer Column Window

The block takes a raster stream of pixels and, for each accepted pixel, builds a vertical column of `TAPS` pixels. The column holds the pixel itself and the pixels in the same column of the `TAPS-1` rows before it. With the default of four taps it keeps three single-line stores, so a downstream 4-row kernel gets one full column per input pixel. It is meant to sit in front of a 2-D filter or convolution datapath, which does the arithmetic itself.

A pixel is never copied from one store to another. Each new row overwrites the store that holds the oldest row. A registered row selector counts modulo the number of stores and decides which store feeds which output lane, so lane 0 always carries the oldest row. Each store is read and written at the same column in the same cycle. The read returns the older row's pixel just before the new pixel replaces it.

A start-of-frame flag marks the first pixel of a frame and an end-of-line flag marks the last pixel of a row. Both streams use valid/ready. The input transfers when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, `out_col` stays unchanged and no input is taken. Input pixels whose column is not yet complete are absorbed without producing an output beat.

Top module: `lw_column_window`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Every output beat packs lane k into bits [k*PIX_W +: PIX_W]. Lane TAPS-1 is the accepted pixel. Lane k < TAPS-1 is the pixel in the same column from (TAPS-1-k) rows earlier, so lane 0 is the oldest row.
- R3: After an accepted pixel with `in_sof` = 1, no output beat appears until `TAPS-1` rows, each closed by an accepted pixel with `in_eol` = 1, have been stored. Every accepted pixel after that produces exactly one output beat, one cycle after acceptance.
- R4: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_col` holds its value. Otherwise `in_ready` is 1.
- R5: An accepted pixel with `in_sof` = 1 restarts the frame at any point, also in the middle of a row. That pixel is treated as row 0, column 0, and rows stored before it are never emitted.
- R6: An accepted pixel with `in_eol` = 1 returns the column address to 0, so rows shorter than `LINE_W` line up column by column.
- R7: Pixels accepted before the first `in_sof` after reset produce no output beats.
- R8: Rows keep rotating through the stores across any number of rows, and the lanes stay correctly ordered for every row of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel |
| in_pix | input | PIX_W | Input pixel |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its row |
| out_valid | output | 1 | Output column valid |
| out_ready | input | 1 | Consumer takes the output column |
| out_col | output | TAPS*PIX_W | Column of pixels, lane 0 is the oldest row |

## Verification
Each fault inside the block shows up at the ports in its own way:
- A row selector that rotates wrongly swaps lanes. The error appears on the first output beat of row TAPS-1, and again at every later row boundary.
- A column counter that does not clear at the end of a line shifts the older lanes by whole pixels in the next row.
- A wrong fill count makes `out_valid` rise one row early or late.

The bench compares every output beat against a model that keeps the whole frame history. It uses mid-row restarts, short rows and random stalls, so these faults are reported on the first affected beat.

// File: rtl/lw_pkg.sv
package lw_pkg;
  // Next value of a counter that wraps at n
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/lw_line_store.sv
module lw_line_store #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64,
  localparam int AW    = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [LINE_W];

  // Read path is combinational: the old row's pixel is seen before the edge overwrites it
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/lw_row_ctrl.sv
module lw_row_ctrl #(
  parameter int LINE_W = 64,
  parameter int NLB    = 3,
  localparam int AW    = (LINE_W > 1) ? $clog2(LINE_W) : 1,
  localparam int SW    = (NLB > 1) ? $clog2(NLB) : 1,
  localparam int FW    = $clog2(NLB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          sof,
  input  logic          eol,
  output logic [AW-1:0] col_addr,
  output logic [SW-1:0] oldest_sel,
  output logic          emit
);
  import lw_pkg::*;

  localparam logic [AW-1:0] LAST_COL = AW'(LINE_W - 1);
  localparam logic [FW-1:0] FULL     = FW'(NLB);

  logic [AW-1:0] col_q, col_eff;
  logic [SW-1:0] sel_q, sel_eff;
  logic [FW-1:0] fill_q, fill_eff;
  logic          armed_q;

  // A frame start forces row 0, column 0, store 0 for the pixel that carries it
  always_comb begin
    col_eff  = sof ? '0 : col_q;
    sel_eff  = sof ? '0 : sel_q;
    fill_eff = sof ? '0 : fill_q;
  end

  assign col_addr   = col_eff;
  assign oldest_sel = sel_eff;
  assign emit       = (armed_q || sof) && (fill_eff == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      sel_q   <= '0;
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else if (accept) begin
      armed_q <= armed_q | sof;
      if (eol || col_eff == LAST_COL) col_q <= '0;
      else                            col_q <= col_eff + 1'b1;
      if (eol) begin
        sel_q  <= SW'(wrap_inc(int'(sel_eff), NLB));
        fill_q <= (fill_eff == FULL) ? fill_eff : fill_eff + 1'b1;
      end else begin
        sel_q  <= sel_eff;
        fill_q <= fill_eff;
      end
    end
  end
endmodule

// File: rtl/lw_tap_route.sv
module lw_tap_route #(
  parameter int PIX_W = 8,
  parameter int NLB   = 3,
  localparam int SW   = (NLB > 1) ? $clog2(NLB) : 1
) (
  input  logic [NLB*PIX_W-1:0]     rd_bus,
  input  logic [SW-1:0]            sel,
  input  logic [PIX_W-1:0]         cur_pix,
  output logic [(NLB+1)*PIX_W-1:0] col_out
);
  // Lane k reads the store that is k rows newer than the oldest one
  always_comb begin
    col_out = '0;
    for (int k = 0; k < NLB; k++) begin
      int idx;
      idx = (int'(sel) + k) % NLB;
      col_out[k*PIX_W +: PIX_W] = rd_bus[idx*PIX_W +: PIX_W];
    end
    col_out[NLB*PIX_W +: PIX_W] = cur_pix;
  end
endmodule

// File: rtl/lw_column_window.sv
module lw_column_window #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64,
  parameter int TAPS   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [PIX_W-1:0]      in_pix,
  input  logic                  in_sof,
  input  logic                  in_eol,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [TAPS*PIX_W-1:0] out_col
);
  localparam int NLB = TAPS - 1;
  localparam int AW  = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam int SW  = (NLB > 1) ? $clog2(NLB) : 1;

  logic                  accept, emit;
  logic [AW-1:0]         col_addr;
  logic [SW-1:0]         oldest_sel;
  logic [NLB*PIX_W-1:0]  rd_bus;
  logic [TAPS*PIX_W-1:0] routed;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  lw_row_ctrl #(.LINE_W(LINE_W), .NLB(NLB)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof), .eol(in_eol),
    .col_addr(col_addr), .oldest_sel(oldest_sel), .emit(emit)
  );

  // The store holding the oldest row takes the incoming row
  for (genvar i = 0; i < NLB; i++) begin : g_store
    logic we;
    assign we = accept && (oldest_sel == SW'(i));
    lw_line_store #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_store (
      .clk(clk), .we(we), .addr(col_addr), .wdata(in_pix),
      .rdata(rd_bus[i*PIX_W +: PIX_W])
    );
  end

  lw_tap_route #(.PIX_W(PIX_W), .NLB(NLB)) i_route (
    .rd_bus(rd_bus), .sel(oldest_sel), .cur_pix(in_pix), .col_out(routed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_col   <= '0;
    end else if (accept) begin
      out_valid <= emit;
      if (emit) out_col <= routed;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lw_column_window_chk.sv
module lw_column_window_chk #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64,
  parameter int TAPS   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_sof,
  input logic                  in_eol,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [TAPS*PIX_W-1:0] out_col
);
  localparam int NLB = TAPS - 1;

  logic [7:0] rows_seen;
  logic       rst_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rows_seen <= '0;
    else if (in_valid && in_ready) begin
      if (in_sof)                          rows_seen <= in_eol ? 8'd1 : 8'd0;
      else if (in_eol && rows_seen != '1)  rows_seen <= rows_seen + 8'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n && rst_seen) p_reset_idle_r1: assert (!out_valid);
    rst_seen <= !rst_n;
  end

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_col));

  p_stall_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_sof_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sof |=> !out_valid);

  p_fill_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> rows_seen >= 8'(NLB));
endmodule

bind lw_column_window lw_column_window_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W), .TAPS(TAPS)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
  .out_ready(out_ready), .out_col(out_col)
);

// File: tb/test_lw_column_window.sv
`timescale 1ns/1ps
module test_lw_column_window;
  localparam int PIX_W  = 8;
  localparam int LINE_W = 8;
  localparam int TAPS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, out_ready = 1'b1;
  logic [PIX_W-1:0] in_pix = '0;
  logic in_ready, out_valid;
  logic [TAPS*PIX_W-1:0] out_col;

  always #4 clk = ~clk;

  lw_column_window #(.PIX_W(PIX_W), .LINE_W(LINE_W), .TAPS(TAPS)) i_lw_column_window (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit stall_on = 0;
  string tag = "R1";

  // Model state: full frame history, expected beats in flight
  logic [TAPS*PIX_W-1:0] q[$];
  int hist[int];
  bit m_armed = 0;
  int m_r = 0, m_c = 0;

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk(tag, 64'(out_valid), 64'(q.size() != 0));
    if (q.size() != 0 && out_valid) chk("R2", 64'(out_col), 64'(q[0]));
  endtask

  task automatic step(input logic v, input logic [PIX_W-1:0] p, input logic s, input logic e,
                      output logic acc);
    logic pop;
    @(negedge clk);
    compare_outputs();
    in_valid  = v; in_pix = p; in_sof = s; in_eol = e;
    out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
    #1;
    chk("R4", 64'(in_ready), 64'(q.size() == 0 || out_ready));
    acc = v && in_ready;
    pop = out_valid && out_ready;
    if (pop && q.size() != 0) void'(q.pop_front());
    if (acc) begin
      if (s) begin hist.delete(); m_r = 0; m_c = 0; m_armed = 1; end
      hist[m_r*LINE_W + m_c] = int'(p);
      if (m_armed && m_r >= TAPS-1)
        q.push_back({p, PIX_W'(hist[(m_r-1)*LINE_W + m_c]),
                        PIX_W'(hist[(m_r-2)*LINE_W + m_c]),
                        PIX_W'(hist[(m_r-3)*LINE_W + m_c])});
      if (e) begin m_r++; m_c = 0; end
      else m_c = (m_c == LINE_W-1) ? 0 : m_c + 1;
    end
  endtask

  task automatic send_pix(input logic s, input logic e);
    logic acc;
    logic [PIX_W-1:0] p;
    p = PIX_W'($urandom);
    do step(($urandom % 5) != 0, p, s, e, acc); while (!acc);
  endtask

  task automatic send_frame(input int rows, input int len, input bit with_sof);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < len; c++)
        send_pix(with_sof && r == 0 && c == 0, c == len-1);
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, acc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 64'(out_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(out_valid), 64'(0));
    chk("R1", 64'(in_ready), 64'(1));

    tag = "R7"; send_frame(4, LINE_W, 0); send_pix(0, 0); idle(3);
    tag = "R3"; send_frame(6, LINE_W, 1); idle(3);
    tag = "R8"; send_frame(9, LINE_W, 1); idle(3);
    tag = "R4"; stall_on = 1; send_frame(6, LINE_W, 1); idle(6); stall_on = 0;
    tag = "R5"; send_frame(4, LINE_W, 1);
    for (int c = 0; c < 3; c++) send_pix(0, 0);
    send_frame(5, LINE_W, 1); idle(3);
    tag = "R6"; stall_on = 1; send_frame(6, 5, 1); idle(6); stall_on = 0;
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule